// File: doc/BRIEF.md
# Pipelined Population Counter with Selectable Latency

This block counts the set bits of a wide input vector. The count comes from a binary tree of pairwise adders. Each tree level halves the number of partial sums. When a level has an odd number of operands, one operand goes straight to the next level without an adder. The block is free-running. It accepts a new vector on every clock and returns a 32-bit zero-extended count a fixed number of cycles later.

Two parameters set the block: the input width and the total latency. Pipeline registers are placed between adder levels by a fixed rule. The levels are split into near-equal groups, and the remainder goes to the earliest groups. The final sum is always registered at the output. If the requested latency is larger than the number of adder levels, the extra stages form a plain delay line after the last sum, so the latency is always exactly the requested value. The block has no reset and no valid signal. A consumer that tracks the issue cycle knows when each count is ready.

Top module: `popc_tree`

## Requirements
- R1: `count_o` equals the number of ones in the `vec_i` value sampled LATENCY clocks earlier, as an unsigned binary number. All bits of `count_o` above the final sum width (levels + 1) are zero.
- R2: Odd input widths give the correct count. At any level with an odd operand count, operand 0 is forwarded unchanged to the next level. Adder i then sums operands 2i and 2i-1 into next-level operand i (i >= 1). At a level with an even count, adder i sums operands 2i+1 and 2i into operand i.
- R3: At every level, the sum of the output operands equals the sum of the input operands. No output operand of level k exceeds 2^k.
- R4: When LATENCY is at most the number of levels L, LATENCY-1 internal register cuts are placed. Let base = L / LATENCY and rem = L mod LATENCY. Each cut lies base levels after the previous cut, or after the input for the first cut. While rem is not used up, each cut also takes one extra level. The output register adds the last cycle.
- R5: When LATENCY exceeds L, cuts sit after every level except the last. The surplus LATENCY - L stages delay the final sum, so the total latency is still exactly LATENCY.
- R6: An input width below 2 is treated as 2, with the missing bits read as zero. A latency below 1 is treated as 1.
- R7: A new vector is accepted on every clock. Back-to-back vectors give independent counts on consecutive cycles, with no bubbles.
- R8: An all-zero vector gives a count of 0. An all-one vector gives a count equal to the input width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; every register samples on the rising edge |
| vec_i | input | IN_W | Vector whose set bits are counted, sampled on every rising edge |
| count_o | output | CNT_W (32) | Zero-extended bit count of the vector sampled LATENCY clocks earlier |

## Verification
Four instances run side by side from one stream:
- A 13-bit tree with latency 3. Its odd levels exercise the forwarded operand. A design that dropped or misaligned the forwarded operand would undercount by exactly that operand's value.
- A 32-bit tree with a single output register.
- A 5-bit tree with latency 6. A design that ignored the surplus stages would deliver counts early, so every result would match the wrong vector.
- A 1-bit tree requesting latency 0. A design without the minimum clamps would either not build or would give results a cycle off.

All-zero and all-one vectors probe the smallest and largest counts. A long back-to-back random stream exposes any stage that holds or skips a value.

// File: rtl/popc_pkg.sv
package popc_pkg;

    // Operand count present after k tree levels, starting from w inputs.
    function automatic int pc_ops(int w, int k);
        int n;
        n = w;
        for (int i = 0; i < k; i++) begin
            n = (n + 1) / 2;
        end
        return n;
    endfunction

    // Number of adder levels needed to reduce w operands to one.
    function automatic int pc_levels(int w);
        int n;
        int l;
        n = w;
        l = 0;
        while (n > 1) begin
            n = (n + 1) / 2;
            l++;
        end
        return l;
    endfunction

    // Bit offset of the operand set entering level k+1 (set 0 is the input).
    function automatic int pc_stage_off(int w, int sw, int k);
        int s;
        s = 0;
        for (int j = 0; j < k; j++) begin
            s += pc_ops(w, j);
        end
        return s * sw;
    endfunction

    // True when a register cut follows level p of an lv-level tree.
    function automatic bit pc_cut_after(int lv, int lat, int p);
        int base;
        int rem;
        int pos;
        base = lv / lat;
        rem  = lv % lat;
        pos  = 0;
        for (int j = 0; j < lat - 1; j++) begin
            pos += base;
            if (rem > 0) begin
                pos++;
                rem--;
            end
            if (pos == p && p < lv) begin
                return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    // Number of cuts that land inside the tree (between two levels).
    function automatic int pc_cut_count(int lv, int lat);
        int c;
        c = 0;
        for (int p = 1; p < lv; p++) begin
            if (pc_cut_after(lv, lat, p)) begin
                c++;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/popc_level.sv
module popc_level #(
    parameter int LVL  = 1,
    parameter int N_IN = 2,
    parameter int SW   = 2,
    localparam int ODD   = N_IN % 2,
    localparam int PAIRS = N_IN / 2,
    localparam int N_OUT = PAIRS + ODD
) (
    input  logic [N_IN*SW-1:0]  ops_i,
    output logic [N_OUT*SW-1:0] ops_o
);

    generate
        if (ODD == 1) begin : g_odd
            // Lowest operand bypasses the adders; pairs are taken from the top.
            always_comb begin
                ops_o[0 +: SW] = ops_i[0 +: SW];
                for (int i = 1; i <= PAIRS; i++) begin
                    ops_o[i*SW +: SW] = ops_i[(2*i)*SW +: SW] + ops_i[(2*i-1)*SW +: SW];
                end
            end
        end else begin : g_even
            always_comb begin
                for (int i = 0; i < PAIRS; i++) begin
                    ops_o[i*SW +: SW] = ops_i[(2*i+1)*SW +: SW] + ops_i[(2*i)*SW +: SW];
                end
            end
        end
    endgenerate

    // Level-local checks: totals are conserved and partial sums stay in range.
    always_comb begin
        int tot_in;
        int tot_out;
        tot_in  = 0;
        tot_out = 0;
        for (int i = 0; i < N_IN; i++) begin
            tot_in += int'(ops_i[i*SW +: SW]);
        end
        for (int i = 0; i < N_OUT; i++) begin
            tot_out += int'(ops_o[i*SW +: SW]);
            p_operand_range_r3: assert (int'(ops_o[i*SW +: SW]) <= (1 << LVL))
                else $error("level %0d operand %0d out of range", LVL, i);
        end
        p_level_sum_r3: assert (tot_in == tot_out)
            else $error("level %0d total %0d != %0d", LVL, tot_out, tot_in);
    end

endmodule

// File: rtl/popc_pipe_reg.sv
module popc_pipe_reg #(
    parameter int BITS = 8
) (
    input  logic            clk_i,
    input  logic [BITS-1:0] d_i,
    output logic [BITS-1:0] q_o
);

    logic [BITS-1:0] ops_d;
    logic [BITS-1:0] ops_q;

    always_comb begin
        ops_d = d_i;
    end

    always_ff @(posedge clk_i) begin
        ops_q <= ops_d;
    end

    assign q_o = ops_q;

endmodule

// File: rtl/popc_out_stage.sv
module popc_out_stage #(
    parameter int SW    = 2,
    parameter int DEPTH = 1,
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic [SW-1:0]    sum_i,
    output logic [CNT_W-1:0] count_o
);

    logic [SW-1:0] chain_d [DEPTH];
    logic [SW-1:0] chain_q [DEPTH];

    always_comb begin
        chain_d[0] = sum_i;
        for (int i = 1; i < DEPTH; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk_i) begin
        for (int i = 0; i < DEPTH; i++) begin
            chain_q[i] <= chain_d[i];
        end
    end

    assign count_o = CNT_W'(chain_q[DEPTH-1]);

endmodule

// File: rtl/popc_tree.sv
module popc_tree
    import popc_pkg::*;
#(
    parameter int IN_W    = 32,
    parameter int LATENCY = 3,
    parameter int CNT_W   = 32
) (
    input  logic             clk_i,
    input  logic [IN_W-1:0]  vec_i,
    output logic [CNT_W-1:0] count_o
);

    localparam int W        = (IN_W < 2) ? 2 : IN_W;
    localparam int LATE     = (LATENCY < 1) ? 1 : LATENCY;
    localparam int L        = pc_levels(W);
    localparam int SW       = L + 1;
    localparam int CUTS     = pc_cut_count(L, LATE);
    localparam int TAIL     = LATE - CUTS;
    localparam int STG_BITS = pc_stage_off(W, SW, L + 1);
    localparam int RAW_BITS = STG_BITS - W * SW;
    localparam int LAST_OFF = pc_stage_off(W, SW, L);

    logic [W-1:0]        vec_pad;
    logic [STG_BITS-1:0] stg_bus;
    logic [RAW_BITS-1:0] raw_bus;

    generate
        if (IN_W < W) begin : g_pad
            assign vec_pad = {{(W-IN_W){1'b0}}, vec_i};
        end else begin : g_nopad
            assign vec_pad = vec_i;
        end

        for (genvar i = 0; i < W; i++) begin : g_in
            assign stg_bus[i*SW +: SW] = {{(SW-1){1'b0}}, vec_pad[i]};
        end

        for (genvar k = 1; k <= L; k++) begin : g_lvl
            localparam int NI = pc_ops(W, k - 1);
            localparam int NO = pc_ops(W, k);
            localparam int SI = pc_stage_off(W, SW, k - 1);
            localparam int SO = pc_stage_off(W, SW, k);
            localparam int RO = SO - W * SW;

            popc_level #(
                .LVL  (k),
                .N_IN (NI),
                .SW   (SW)
            ) u_lvl (
                .ops_i (stg_bus[SI +: NI*SW]),
                .ops_o (raw_bus[RO +: NO*SW])
            );

            if (k < L && pc_cut_after(L, LATE, k)) begin : g_cut
                popc_pipe_reg #(
                    .BITS (NO*SW)
                ) u_cut (
                    .clk_i (clk_i),
                    .d_i   (raw_bus[RO +: NO*SW]),
                    .q_o   (stg_bus[SO +: NO*SW])
                );
            end else begin : g_wire
                assign stg_bus[SO +: NO*SW] = raw_bus[RO +: NO*SW];
            end
        end
    endgenerate

    popc_out_stage #(
        .SW    (SW),
        .DEPTH (TAIL),
        .CNT_W (CNT_W)
    ) u_out (
        .clk_i   (clk_i),
        .sum_i   (stg_bus[LAST_OFF +: SW]),
        .count_o (count_o)
    );

    // Cycles since start, used only to hold off checks until the pipe is full.
    logic [31:0] warm_q = '0;
    always_ff @(posedge clk_i) begin
        if (warm_q < 32'(LATE)) begin
            warm_q <= warm_q + 32'd1;
        end
    end

    p_count_bound_r1: assert property (@(posedge clk_i) disable iff (warm_q < 32'(LATE))
        count_o <= CNT_W'(W))
        else $error("count above input width");

    p_upper_zero_r1: assert property (@(posedge clk_i) disable iff (warm_q < 32'(LATE))
        (count_o >> SW) == '0)
        else $error("count bits above sum width set");

endmodule

// File: tb/popc_tree_tb.sv
`timescale 1ns/1ps
module popc_tree_tb;

    localparam int LAT_A = 3;   // 13-bit, 4 levels
    localparam int LAT_B = 1;   // 32-bit, 5 levels
    localparam int LAT_C = 6;   // 5-bit, 3 levels, surplus stages
    localparam int LAT_D = 1;   // requested 0, raised to 1
    localparam int HN    = 256;

    localparam int NT = 12;
    localparam logic [63:0] TBL_VEC [NT] = '{
        64'h0, 64'h1, 64'h1000, 64'h1FFF, 64'h0AAA, 64'h1555,
        64'h00FF, 64'h1F00, 64'h0101, 64'h1801, 64'hFFFF_FFFF_FFFF_E000, 64'h0F0F
    };
    localparam int TBL_EXP [NT] = '{0, 1, 1, 13, 6, 7, 8, 5, 2, 3, 0, 8};

    logic        clk = 1'b0;
    logic [63:0] vec = '0;
    logic [31:0] cnt_a, cnt_b, cnt_c, cnt_d;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;
    logic [63:0] hist   [HN];
    int          hist13 [HN];

    always #4 clk = ~clk;

    popc_tree #(.IN_W(13), .LATENCY(LAT_A), .CNT_W(32)) u_dut (
        .clk_i(clk), .vec_i(vec[12:0]), .count_o(cnt_a));
    popc_tree #(.IN_W(32), .LATENCY(LAT_B), .CNT_W(32)) u_wide (
        .clk_i(clk), .vec_i(vec[31:0]), .count_o(cnt_b));
    popc_tree #(.IN_W(5), .LATENCY(LAT_C), .CNT_W(32)) u_deep (
        .clk_i(clk), .vec_i(vec[4:0]), .count_o(cnt_c));
    popc_tree #(.IN_W(1), .LATENCY(0), .CNT_W(32)) u_tiny (
        .clk_i(clk), .vec_i(vec[0:0]), .count_o(cnt_d));

    task automatic check(input logic [31:0] act, input int exp, input string tag);
        checks++;
        if (act !== 32'(exp)) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Check every instance against the vector issued its latency ago, then issue v.
    task automatic step(input logic [63:0] v, input int e13, input string tag);
        logic [63:0] old;
        @(negedge clk);
        if (cyc >= LAT_A) check(cnt_a, hist13[(cyc-LAT_A)%HN], {tag, " R2 u_dut"});
        if (cyc >= LAT_B) begin
            old = hist[(cyc-LAT_B)%HN];
            check(cnt_b, $countones(old[31:0]), {tag, " R4 u_wide"});
        end
        if (cyc >= LAT_C) begin
            old = hist[(cyc-LAT_C)%HN];
            check(cnt_c, $countones(old[4:0]), {tag, " R5 u_deep"});
        end
        if (cyc >= LAT_D) begin
            old = hist[(cyc-LAT_D)%HN];
            check(cnt_d, int'(old[0]), {tag, " R6 u_tiny"});
        end
        vec = v;
        hist[cyc%HN]   = v;
        hist13[cyc%HN] = e13;
        cyc++;
    endtask

    initial begin
        logic [63:0] r;
        // R1, R3: table of vectors with known 13-bit counts
        for (int i = 0; i < NT; i++) begin
            step(TBL_VEC[i], TBL_EXP[i], "R1/R3 table");
        end
        // R8: extremes, alternated to exercise every stage
        for (int i = 0; i < 6; i++) begin
            step('0, 0, "R8 zeros");
            step('1, 13, "R8 ones");
        end
        // R7: back-to-back random vectors
        for (int i = 0; i < 300; i++) begin
            r = {$urandom, $urandom};
            step(r, $countones(r[12:0]), "R7 stream");
        end
        // drain every pipe
        for (int i = 0; i < LAT_C + 1; i++) begin
            step('0, 0, "R7 drain");
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #1600000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule